// File: doc/BRIEF.md
# Load-Store Address Hazard Checker

This block decides, cycle by cycle, whether a load whose effective address is known may go on to access memory. It keeps its own table of the stores that are still in flight in the speculative in-order window: each slot records whether it is occupied, whether the store's address has been computed, that address, and the store's age tag. A single load is held in a pending register. Its address and age are compared against every slot. The load is granted only when no older store is still missing its address and no older store targets the same word address.

Stores update memory only when they commit from the head of the window, so memory writes happen in program order. Write-after-write and write-after-read hazards through memory therefore cannot occur, and the checker only guards read-after-write. The match is deliberately conservative: any equal address on an older uncommitted store blocks the load until that store commits. A flush empties both the store table and the pending load.

Top module: `ld_st_hazard_check`

## Requirements
- R1: After reset no load is pending, `ld_rdy` is 1, and `ld_grant`, `ld_stall_unk` and `ld_stall_alias` are all 0.
- R2: A request presented with `ld_req_vld` while `ld_rdy` is 1 is captured at that clock edge. From the next cycle until it is granted, exactly one of `ld_grant` or a stall output (`ld_stall_unk` or `ld_stall_alias`) is high.
- R3: A pending load raises `ld_stall_unk` while any occupied slot holding an older store has no address yet.
- R4: A pending load raises `ld_stall_alias` while any occupied slot holding an older store has a known address equal to the load address.
- R5: A pending load with no older store that is unresolved or aliasing raises `ld_grant`.
- R6: A store counts as older only when (load age − store age) mod 2^TW is nonzero and below 2^(TW−1). Younger stores never stall a load, and this holds across tag wrap.
- R7: A commit frees its slot at the clock edge, so a stall caused only by that store drops in the cycle after the commit is presented.
- R8: A flush empties every slot and drops the pending load. In the next cycle `ld_rdy` is 1 and no output is asserted.
- R9: `ld_grant` lasts one cycle and retires the pending load. `ld_rdy` is 1 during the grant cycle, so a new request can be captured at the same edge.
- R10: When several store operations name the same slot in one cycle, allocate wins over commit and commit wins over an address write. An address write to an empty slot has no effect.
- R11: The address comparison covers all AW bits. Addresses that differ in any bit, including the top bit, do not alias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Discard all store slots and the pending load |
| st_alloc_vld | input | 1 | Occupy a slot with a new store, address unknown |
| st_alloc_slot | input | $clog2(NST) | Slot being occupied |
| st_alloc_age | input | TW | Age tag of the new store |
| st_addr_vld | input | 1 | Store address has been computed |
| st_addr_slot | input | $clog2(NST) | Slot receiving the address |
| st_addr | input | AW | Store word address |
| st_commit_vld | input | 1 | Store has written memory and leaves the window |
| st_commit_slot | input | $clog2(NST) | Slot being freed |
| ld_req_vld | input | 1 | Load request with computed address |
| ld_req_addr | input | AW | Load word address |
| ld_req_age | input | TW | Load age tag |
| ld_rdy | output | 1 | A new load request can be captured |
| ld_grant | output | 1 | Pending load may access memory |
| ld_stall_unk | output | 1 | Pending load waits on an older store with unknown address |
| ld_stall_alias | output | 1 | Pending load waits on an older store to the same address |

## Verification
The bench drives age tags through the wrap point, so a checker that compares tags as plain numbers will stall on younger stores or pass older ones. It commits and allocates the same slot in one cycle, and writes an address while committing. A wrong precedence shows up as a load that is granted too early or never released. It uses addresses that differ only in the top bit, which catches a truncated comparator that reports false aliases. It also flushes with a stalled load pending, where a design that keeps stale entries would stall the next load. Back-to-back requests during a grant cycle check that `ld_rdy` does not lose a cycle.

// File: rtl/ld_st_hazard_check.sv
module ld_st_hazard_check #(
  parameter int NST = 8,
  parameter int AW  = 32,
  parameter int TW  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic                   st_alloc_vld,
  input  logic [$clog2(NST)-1:0] st_alloc_slot,
  input  logic [TW-1:0]          st_alloc_age,
  input  logic                   st_addr_vld,
  input  logic [$clog2(NST)-1:0] st_addr_slot,
  input  logic [AW-1:0]          st_addr,
  input  logic                   st_commit_vld,
  input  logic [$clog2(NST)-1:0] st_commit_slot,
  input  logic                   ld_req_vld,
  input  logic [AW-1:0]          ld_req_addr,
  input  logic [TW-1:0]          ld_req_age,
  output logic                   ld_rdy,
  output logic                   ld_grant,
  output logic                   ld_stall_unk,
  output logic                   ld_stall_alias
);
  localparam int SW = $clog2(NST);

  logic [NST-1:0] st_v_q, st_k_q, unk_hit, alias_hit;
  logic [AW-1:0]  st_a_q [NST];
  logic [TW-1:0]  st_g_q [NST];
  logic           pend_q;
  logic [AW-1:0]  pend_addr_q;
  logic [TW-1:0]  pend_age_q;

  for (genvar i = 0; i < NST; i++) begin : g_slot
    logic          sel_alloc, sel_commit, sel_addr, older;
    logic [TW-1:0] diff;

    assign sel_alloc  = st_alloc_vld  && st_alloc_slot  == SW'(i);
    assign sel_commit = st_commit_vld && st_commit_slot == SW'(i);
    assign sel_addr   = st_addr_vld   && st_addr_slot   == SW'(i);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_v_q[i] <= 1'b0;
        st_k_q[i] <= 1'b0;
        st_a_q[i] <= '0;
        st_g_q[i] <= '0;
      end else if (flush) begin
        st_v_q[i] <= 1'b0;
        st_k_q[i] <= 1'b0;
      end else if (sel_alloc) begin
        st_v_q[i] <= 1'b1;
        st_k_q[i] <= 1'b0;
        st_g_q[i] <= st_alloc_age;
      end else if (sel_commit) begin
        st_v_q[i] <= 1'b0;
        st_k_q[i] <= 1'b0;
      end else if (sel_addr && st_v_q[i]) begin
        st_k_q[i] <= 1'b1;
        st_a_q[i] <= st_addr;
      end
    end

    assign diff         = pend_age_q - st_g_q[i];
    assign older        = st_v_q[i] && diff != '0 && !diff[TW-1];
    assign unk_hit[i]   = older && !st_k_q[i];
    assign alias_hit[i] = older && st_k_q[i] && st_a_q[i] == pend_addr_q;
  end

  assign ld_stall_unk   = pend_q && |unk_hit;
  assign ld_stall_alias = pend_q && |alias_hit;
  assign ld_grant       = pend_q && !(|unk_hit) && !(|alias_hit);
  assign ld_rdy         = !pend_q || ld_grant;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
      pend_age_q  <= '0;
    end else if (flush) begin
      pend_q <= 1'b0;
    end else if (ld_req_vld && ld_rdy) begin
      pend_q      <= 1'b1;
      pend_addr_q <= ld_req_addr;
      pend_age_q  <= ld_req_age;
    end else if (ld_grant) begin
      pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ld_st_hazard_check_sva.sv
module ld_st_hazard_check_sva #(
  parameter int NST = 8,
  parameter int AW  = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   flush,
  input logic                   ld_req_vld,
  input logic                   ld_rdy,
  input logic                   ld_grant,
  input logic                   ld_stall_unk,
  input logic                   ld_stall_alias,
  input logic                   pend_q,
  input logic [AW-1:0]          pend_addr_q,
  input logic                   st_alloc_vld,
  input logic [$clog2(NST)-1:0] st_alloc_slot,
  input logic                   st_commit_vld,
  input logic [$clog2(NST)-1:0] st_commit_slot,
  input logic [NST-1:0]         st_v_q
);
  a_r2_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> $countones({ld_grant, ld_stall_unk || ld_stall_alias}) == 1);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_q |-> !ld_grant && !ld_stall_unk && !ld_stall_alias && ld_rdy);

  a_r2_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && !ld_grant && !flush |=> pend_q && $stable(pend_addr_q));

  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !pend_q && st_v_q == '0);

  a_r9_grant_retires: assert property (@(posedge clk) disable iff (!rst_n)
    ld_grant && !ld_req_vld |=> !pend_q);

  a_r7_commit_frees: assert property (@(posedge clk) disable iff (!rst_n)
    st_commit_vld && !flush && !(st_alloc_vld && st_alloc_slot == st_commit_slot)
    |=> !st_v_q[$past(st_commit_slot)]);

  a_r10_alloc_wins: assert property (@(posedge clk) disable iff (!rst_n)
    st_alloc_vld && !flush |=> st_v_q[$past(st_alloc_slot)]);
endmodule

bind ld_st_hazard_check ld_st_hazard_check_sva #(.NST(NST), .AW(AW)) u_sva (
  .clk(clk), .rst_n(rst_n), .flush(flush), .ld_req_vld(ld_req_vld),
  .ld_rdy(ld_rdy), .ld_grant(ld_grant), .ld_stall_unk(ld_stall_unk),
  .ld_stall_alias(ld_stall_alias), .pend_q(pend_q), .pend_addr_q(pend_addr_q),
  .st_alloc_vld(st_alloc_vld), .st_alloc_slot(st_alloc_slot),
  .st_commit_vld(st_commit_vld), .st_commit_slot(st_commit_slot), .st_v_q(st_v_q)
);

// File: tb/tb_ld_st_hazard_check.sv
module tb_ld_st_hazard_check;
  localparam int NST = 8;
  localparam int AW  = 32;
  localparam int TW  = 4;
  localparam int SW  = $clog2(NST);

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic st_alloc_vld = 1'b0, st_addr_vld = 1'b0, st_commit_vld = 1'b0, ld_req_vld = 1'b0;
  logic [SW-1:0] st_alloc_slot = '0, st_addr_slot = '0, st_commit_slot = '0;
  logic [TW-1:0] st_alloc_age = '0, ld_req_age = '0;
  logic [AW-1:0] st_addr = '0, ld_req_addr = '0;
  logic ld_rdy, ld_grant, ld_stall_unk, ld_stall_alias;

  always #2 clk = ~clk;

  ld_st_hazard_check #(.NST(NST), .AW(AW), .TW(TW)) dut (.*);

  int nchk = 0, nfail = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  bit          m_v [NST];
  bit          m_k [NST];
  logic [AW-1:0] m_a [NST];
  int          m_g [NST];
  bit          m_p = 1'b0;
  logic [AW-1:0] m_pa;
  int          m_pg;

  function automatic bit is_older(int ld_age, int st_age);
    int d = (ld_age - st_age + (1 << TW)) % (1 << TW);
    return d > 0 && d < (1 << (TW - 1));
  endfunction

  function automatic void expect_now(output bit eu, output bit ea, output bit eg, output bit er);
    eu = 0; ea = 0;
    for (int i = 0; i < NST; i++)
      if (m_p && m_v[i] && is_older(m_pg, m_g[i])) begin
        if (!m_k[i]) eu = 1;
        else if (m_a[i] == m_pa) ea = 1;
      end
    eg = m_p && !eu && !ea;
    er = !m_p || eg;
  endfunction

  task automatic chk(logic act, bit exp, string what);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %b expected %b", cur_req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    bit eu, ea, eg, er;
    expect_now(eu, ea, eg, er);
    chk(ld_rdy, er, "ld_rdy");
    chk(ld_grant, eg, "ld_grant");
    chk(ld_stall_unk, eu, "ld_stall_unk");
    chk(ld_stall_alias, ea, "ld_stall_alias");
  endtask

  task automatic step();
    bit eu, ea, eg, er;
    expect_now(eu, ea, eg, er);
    @(posedge clk);
    if (flush) begin
      for (int i = 0; i < NST; i++) begin m_v[i] = 0; m_k[i] = 0; end
      m_p = 0;
    end else begin
      if (st_addr_vld && m_v[st_addr_slot]) begin
        m_k[st_addr_slot] = 1; m_a[st_addr_slot] = st_addr;
      end
      if (st_commit_vld) begin m_v[st_commit_slot] = 0; m_k[st_commit_slot] = 0; end
      if (st_alloc_vld) begin
        m_v[st_alloc_slot] = 1; m_k[st_alloc_slot] = 0; m_g[st_alloc_slot] = int'(st_alloc_age);
      end
      if (ld_req_vld && er) begin m_p = 1; m_pa = ld_req_addr; m_pg = int'(ld_req_age); end
      else if (eg) m_p = 0;
    end
    @(negedge clk);
    compare_all();
    st_alloc_vld = 0; st_addr_vld = 0; st_commit_vld = 0; ld_req_vld = 0; flush = 0;
  endtask

  task automatic alloc(int s, int age);
    st_alloc_vld = 1; st_alloc_slot = SW'(s); st_alloc_age = TW'(age);
  endtask
  task automatic saddr(int s, logic [AW-1:0] a);
    st_addr_vld = 1; st_addr_slot = SW'(s); st_addr = a;
  endtask
  task automatic commit(int s);
    st_commit_vld = 1; st_commit_slot = SW'(s);
  endtask
  task automatic load(logic [AW-1:0] a, int age);
    ld_req_vld = 1; ld_req_addr = a; ld_req_age = TW'(age);
  endtask

  task automatic finish_up();
    if (done) return;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    for (int i = 0; i < NST; i++) begin m_v[i] = 0; m_k[i] = 0; m_a[i] = '0; m_g[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R1";
    compare_all();
    step();

    cur_req = "R5";
    load(32'h100, 5); step(); step();

    cur_req = "R3";
    alloc(0, 2); step();
    load(32'h100, 5); step(); step();
    cur_req = "R5";
    saddr(0, 32'h200); step(); step();

    cur_req = "R4";
    load(32'h200, 5); step(); step(); step();
    cur_req = "R7";
    commit(0); step(); step();

    cur_req = "R6";
    alloc(1, 9); step(); saddr(1, 32'h300); step();
    load(32'h300, 5); step(); step();
    commit(1); step();
    alloc(2, 14); step(); saddr(2, 32'h300); step();
    load(32'h300, 2); step(); step();
    commit(2); step(); step();

    cur_req = "R11";
    alloc(3, 1); step(); saddr(3, 32'h8000_0300); step();
    load(32'h0000_0300, 3); step(); step();
    cur_req = "R4";
    load(32'h8000_0300, 3); step(); step();
    cur_req = "R8";
    flush = 1; step(); step();
    load(32'h8000_0300, 3); step(); step();

    cur_req = "R10";
    alloc(4, 6); step(); saddr(4, 32'h40); step();
    commit(4); alloc(4, 7); step();
    load(32'h40, 9); step(); step();
    saddr(4, 32'h44); commit(4); step(); step();
    saddr(5, 32'h40); step();
    load(32'h40, 9); step(); step();

    cur_req = "R9";
    load(32'h10, 1); step();
    load(32'h14, 2); step();
    load(32'h18, 3); step(); step();

    cur_req = "R2";
    for (int n = 0; n < 600; n++) begin
      if ($urandom_range(0, 3) == 0) alloc(int'($urandom_range(0, NST - 1)), int'($urandom_range(0, 15)));
      if ($urandom_range(0, 2) == 0) saddr(int'($urandom_range(0, NST - 1)), AW'($urandom_range(0, 3)));
      if ($urandom_range(0, 3) == 0) commit(int'($urandom_range(0, NST - 1)));
      if ($urandom_range(0, 1) == 0) load(AW'($urandom_range(0, 3)), int'($urandom_range(0, 15)));
      if ($urandom_range(0, 60) == 0) flush = 1;
      step();
    end
    finish_up();
  end
endmodule